// File: doc/BRIEF.md
# Event-Triggered Single-Channel Byte Copy Engine

This block is one channel of a memory copy engine working in linear addressing mode. Software programs a source start address, a destination start address, a source length, a destination length and a cell length, then sets the channel enable. Each trigger moves one cell of bytes from the source buffer to the destination buffer and then waits for the next one. A trigger is either a hardware start event or a software force strobe. The total length of a block is the larger of the two buffer lengths. Each pointer runs through its own buffer and wraps back to its start address independently of the other, so a short source can be replicated into a longer destination.

The channel ends a block in one of two ways. Normal completion happens when block-length bytes have moved. Abort happens on an abort event or, when enabled, after a byte equal to a programmed pattern has been written. Either ending clears the channel enable and rewinds both pointers. Three sticky status flags record cell done, block done and abort. Software clears them by writing ones. Each flag can drive the interrupt line through its own enable bit.

The control path is a three-state machine. IDLE goes to READ when the channel is enabled and a trigger arrives (transition LAUNCH). In IDLE an abort event with the channel enabled stays in IDLE and aborts (transition IDLE_ABORT). READ always goes to WRITE (transition FETCHED). WRITE goes back to READ when the cell still has bytes left (transition NEXT_BYTE). WRITE goes to IDLE on cell end, block end or abort (transitions CELL_END, BLOCK_END, BYTE_ABORT).

Top module: `dma_lane`

## Requirements
- R1: After reset the channel is disabled, all status flags and the interrupt are low, and no memory read or write is issued.
- R2: A trigger is a high cycle of `force_go` or `start_evt`. It starts one cell only while `chan_en` is high and the channel is in IDLE. Otherwise it is ignored and nothing is written.
- R3: Each byte takes one cycle with `mem_rd` high at the source address, then one cycle with `mem_wr` high at the destination address. The write data is the byte the memory returns one cycle after the read.
- R4: The length fields are 8 bits wide, with code 0 meaning 256 and any other code meaning its own value. The block length is the larger of the source and destination lengths. When it has been moved, stat_flags bit 1 (block done) and bit 0 (cell done) are set and `chan_en` clears.
- R5: The source address runs from its base and returns to the base after source-length bytes. The destination address does the same with the destination length, independently of the source.
- R6: A trigger moves the smaller of the cell length and the bytes remaining in the block. A cell length above the block length therefore moves the whole block, and the final cell of a block is shortened.
- R7: At the end of a cell that does not finish the block, only stat_flags bit 0 is set, and the channel stays enabled and waits.
- R8: With `pat_en` high, a written byte equal to `pat_val` ends the transfer after that write. It sets stat_flags bit 2 (abort), does not set bit 1, and clears `chan_en`.
- R9: An abort event with the channel enabled in IDLE aborts at once. During a transfer it stops the channel after the write of the current byte. Either way it sets bit 2, leaves bit 1 clear and clears `chan_en`.
- R10: After a block end or an abort, both pointers return to offset 0, so the next block starts at the base addresses.
- R11: A flag is cleared by a one on the matching `flag_clr` bit. If a flag is set and cleared in the same cycle, the set wins.
- R12: `lane_irq` is high exactly when some flag bit is set and the matching `irq_en` bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_set | input | 1 | Pulse that sets the channel enable |
| force_go | input | 1 | Software trigger strobe |
| start_evt | input | 1 | Hardware start event |
| abort_evt | input | 1 | Hardware abort event |
| cfg_src_base | input | AW | Source start address |
| cfg_dst_base | input | AW | Destination start address |
| cfg_src_len | input | LW | Source length code (0 means 256) |
| cfg_dst_len | input | LW | Destination length code (0 means 256) |
| cfg_cell_len | input | LW | Cell length code (0 means 256) |
| pat_en | input | 1 | Enables pattern-match abort |
| pat_val | input | DW | Pattern byte |
| flag_clr | input | 3 | Write-one-to-clear strobes for the flags |
| irq_en | input | 3 | Per-flag interrupt enables |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid the cycle after `mem_rd` |
| chan_en | output | 1 | Channel enable state |
| stat_flags | output | 3 | Bit 0 cell done, bit 1 block done, bit 2 abort |
| lane_irq | output | 1 | Interrupt line |

## Verification
Two pairs of events can fall in the same cycle. The first is a status flag being set while software clears it. The bench holds the cell-done clear strobe high across a whole transfer and watches the flag at every cycle. It passes when the flag is seen high for at least one cycle and is low afterwards. The second is an abort event while a byte is in flight. The bench raises the abort on the cycle of the first read, so exactly one byte must reach the scoreboard. It then expects abort set, block done clear, and the next block starting again at both base addresses.

// File: rtl/dma_lane_pkg.sv
package dma_lane_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } lane_state_t;

    localparam int FLAG_CELL = 0;
    localparam int FLAG_BLK  = 1;
    localparam int FLAG_ABT  = 2;
    localparam int NFLAG     = 3;

endpackage

// File: rtl/dma_lane_ptr.sv
module dma_lane_ptr #(
    parameter int AW = 16,
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] base,
    input  logic [LW:0]   len,
    input  logic          step,
    input  logic          rewind,
    output logic [AW-1:0] addr
);
    logic [LW-1:0] off_q;
    logic [LW:0]   nxt;

    assign nxt  = {1'b0, off_q} + {{LW{1'b0}}, 1'b1};
    assign addr = base + AW'(off_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            off_q <= '0;
        else if (rewind)
            off_q <= '0;
        else if (step)
            off_q <= (nxt >= len) ? '0 : nxt[LW-1:0];
    end

    // R5
    off_in_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && $stable(len)) |=> ({1'b0, off_q} < len));

    // R10
    rewind_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rewind |=> (off_q == '0));

endmodule

// File: rtl/dma_lane_status.sv
module dma_lane_status #(
    parameter int NF = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set,
    input  logic [NF-1:0] clr,
    input  logic [NF-1:0] ien,
    output logic [NF-1:0] flags,
    output logic          irq
);
    for (genvar i = 0; i < NF; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                flags[i] <= 1'b0;
            else if (set[i])
                flags[i] <= 1'b1;
            else if (clr[i])
                flags[i] <= 1'b0;
        end

        // R11
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> flags[i]);

        // R11
        clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !set[i]) |=> !flags[i]);
    end

    assign irq = |(flags & ien);

endmodule

// File: rtl/dma_lane_ctrl.sv
module dma_lane_ctrl
    import dma_lane_pkg::*;
#(
    parameter int LW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          trig,
    input  logic          abort_evt,
    input  logic          pat_en,
    input  logic [DW-1:0] pat_val,
    input  logic [DW-1:0] byte_in,
    input  logic [LW:0]   blk_len,
    input  logic [LW:0]   cell_len,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic          step,
    output logic          rewind,
    output logic          en_clr,
    output logic          ev_cell,
    output logic          ev_blk,
    output logic          ev_abt
);
    lane_state_t state_q, state_d;

    logic [LW:0] done_q;
    logic [LW:0] left_q;
    logic [LW:0] remain;
    logic [LW:0] take;
    logic        pend_q;
    logic        byte_end;
    logic        hit;
    logic        stop_abt;
    logic        idle_abt;
    logic        blk_end;
    logic        cell_end;
    logic        launch;

    localparam logic [LW:0] ONE = {{LW{1'b0}}, 1'b1};

    always_comb begin
        remain   = blk_len - done_q;
        take     = (cell_len < remain) ? cell_len : remain;
        byte_end = (state_q == ST_WRITE);
        hit      = pat_en && (byte_in == pat_val);
        stop_abt = byte_end && (pend_q || abort_evt || hit);
        idle_abt = (state_q == ST_IDLE) && en && abort_evt;
        launch   = (state_q == ST_IDLE) && en && trig && !abort_evt;
        blk_end  = byte_end && !stop_abt && ((done_q + ONE) >= blk_len);
        cell_end = byte_end && !stop_abt && (left_q == ONE);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (launch) state_d = ST_READ;
            ST_READ:  state_d = ST_WRITE;
            ST_WRITE: begin
                if (stop_abt || blk_end || cell_end)
                    state_d = ST_IDLE;
                else
                    state_d = ST_READ;
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // datapath counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= '0;
            left_q <= '0;
            pend_q <= 1'b0;
        end else begin
            if (rewind)
                done_q <= '0;
            else if (step)
                done_q <= done_q + ONE;

            if (launch)
                left_q <= take;
            else if (step)
                left_q <= left_q - ONE;

            if (state_q == ST_IDLE)
                pend_q <= 1'b0;
            else if (abort_evt)
                pend_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        mem_rd  = (state_q == ST_READ);
        mem_wr  = byte_end;
        step    = byte_end;
        ev_abt  = stop_abt || idle_abt;
        ev_blk  = blk_end;
        ev_cell = blk_end || cell_end;
        rewind  = ev_abt || ev_blk;
        en_clr  = ev_abt || ev_blk;
    end

    // R3
    rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> mem_wr);

    // R6
    done_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(blk_len) |-> (done_q <= blk_len));

    // R9
    abort_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_WRITE) && abort_evt) |=> (state_q == ST_IDLE));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) && !en) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/dma_lane.sv
module dma_lane
    import dma_lane_pkg::*;
#(
    parameter int AW = 16,
    parameter int LW = 8,
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_set,
    input  logic              force_go,
    input  logic              start_evt,
    input  logic              abort_evt,
    input  logic [AW-1:0]     cfg_src_base,
    input  logic [AW-1:0]     cfg_dst_base,
    input  logic [LW-1:0]     cfg_src_len,
    input  logic [LW-1:0]     cfg_dst_len,
    input  logic [LW-1:0]     cfg_cell_len,
    input  logic              pat_en,
    input  logic [DW-1:0]     pat_val,
    input  logic [NFLAG-1:0]  flag_clr,
    input  logic [NFLAG-1:0]  irq_en,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic [DW-1:0]     mem_rdata,
    output logic              chan_en,
    output logic [NFLAG-1:0]  stat_flags,
    output logic              lane_irq
);
    logic [LW:0]      src_len;
    logic [LW:0]      dst_len;
    logic [LW:0]      cell_len;
    logic [LW:0]      blk_len;
    logic [AW-1:0]    src_addr;
    logic [AW-1:0]    dst_addr;
    logic             step;
    logic             rewind;
    logic             en_clr;
    logic             ev_cell;
    logic             ev_blk;
    logic             ev_abt;
    logic [NFLAG-1:0] ev_set;

    // a zero code stands for the full 2**LW length
    assign src_len  = {(cfg_src_len  == '0), cfg_src_len};
    assign dst_len  = {(cfg_dst_len  == '0), cfg_dst_len};
    assign cell_len = {(cfg_cell_len == '0), cfg_cell_len};
    assign blk_len  = (src_len > dst_len) ? src_len : dst_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            chan_en <= 1'b0;
        else if (en_clr)
            chan_en <= 1'b0;
        else if (en_set)
            chan_en <= 1'b1;
    end

    dma_lane_ctrl #(.LW(LW), .DW(DW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (chan_en),
        .trig      (force_go | start_evt),
        .abort_evt (abort_evt),
        .pat_en    (pat_en),
        .pat_val   (pat_val),
        .byte_in   (mem_rdata),
        .blk_len   (blk_len),
        .cell_len  (cell_len),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .step      (step),
        .rewind    (rewind),
        .en_clr    (en_clr),
        .ev_cell   (ev_cell),
        .ev_blk    (ev_blk),
        .ev_abt    (ev_abt)
    );

    dma_lane_ptr #(.AW(AW), .LW(LW)) u_src (
        .clk    (clk),
        .rst_n  (rst_n),
        .base   (cfg_src_base),
        .len    (src_len),
        .step   (step),
        .rewind (rewind),
        .addr   (src_addr)
    );

    dma_lane_ptr #(.AW(AW), .LW(LW)) u_dst (
        .clk    (clk),
        .rst_n  (rst_n),
        .base   (cfg_dst_base),
        .len    (dst_len),
        .step   (step),
        .rewind (rewind),
        .addr   (dst_addr)
    );

    always_comb begin
        ev_set            = '0;
        ev_set[FLAG_CELL] = ev_cell;
        ev_set[FLAG_BLK]  = ev_blk;
        ev_set[FLAG_ABT]  = ev_abt;
    end

    dma_lane_status #(.NF(NFLAG)) u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (ev_set),
        .clr   (flag_clr),
        .ien   (irq_en),
        .flags (stat_flags),
        .irq   (lane_irq)
    );

    assign mem_addr  = mem_wr ? dst_addr : src_addr;
    assign mem_wdata = mem_rdata;

    // R2
    rd_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> chan_en);

    // R4
    self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_blk |=> !chan_en);

    // R9
    abort_no_blk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_abt |=> (stat_flags[FLAG_ABT] && !$rose(stat_flags[FLAG_BLK])));

endmodule

// File: tb/sim_dma_lane.sv
module sim_dma_lane;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en_set = 0, force_go = 0, start_evt = 0, abort_evt = 0;
    logic [AW-1:0] cfg_src_base = '0, cfg_dst_base = '0;
    logic [7:0]    cfg_src_len = 8'd1, cfg_dst_len = 8'd1, cfg_cell_len = 8'd1;
    logic          pat_en = 0;
    logic [7:0]    pat_val = '0;
    logic [2:0]    flag_clr = '0, irq_en = '0;
    logic          mem_rd, mem_wr, chan_en, lane_irq;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic [7:0]    mem_rdata = '0;
    logic [2:0]    stat_flags;

    always #2 clk = ~clk;

    dma_lane #(.AW(AW), .LW(8), .DW(8)) u0 (
        .clk(clk), .rst_n(rst_n), .en_set(en_set), .force_go(force_go),
        .start_evt(start_evt), .abort_evt(abort_evt),
        .cfg_src_base(cfg_src_base), .cfg_dst_base(cfg_dst_base),
        .cfg_src_len(cfg_src_len), .cfg_dst_len(cfg_dst_len),
        .cfg_cell_len(cfg_cell_len), .pat_en(pat_en), .pat_val(pat_val),
        .flag_clr(flag_clr), .irq_en(irq_en), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .chan_en(chan_en), .stat_flags(stat_flags), .lane_irq(lane_irq)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    logic [7:0] mem [1024];
    initial for (int i = 0; i < 1024; i++) mem[i] = pat(i);

    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    int checks = 0, fails = 0, wr_seen = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // scoreboard
    typedef struct packed { logic [AW-1:0] a; logic [7:0] d; } wr_t;
    wr_t q[$];

    always @(negedge clk) begin
        if (rst_n && mem_wr) begin
            wr_seen++;
            if (q.size() == 0) begin
                chk(0, "R2 unexpected write addr", int'(mem_addr), -1);
            end else begin
                wr_t w;
                w = q.pop_front();
                chk(mem_addr == w.a, "R5 write address", int'(mem_addr), int'(w.a));
                chk(mem_wdata == w.d, "R3 write data", int'(mem_wdata), int'(w.d));
            end
        end
    end

    // reference model
    int m_src, m_dst, m_slen, m_dlen, m_clen, m_blk, m_done, m_soff, m_doff;

    task automatic rewind_model();
        m_done = 0; m_soff = 0; m_doff = 0;
    endtask

    task automatic cfg(input int sb, input int db, input int sl, input int dl, input int cl);
        @(negedge clk);
        cfg_src_base = AW'(sb); cfg_dst_base = AW'(db);
        cfg_src_len = 8'(sl); cfg_dst_len = 8'(dl); cfg_cell_len = 8'(cl);
        m_src = sb; m_dst = db; m_slen = sl; m_dlen = dl; m_clen = cl;
        m_blk = (sl > dl) ? sl : dl;
    endtask

    task automatic model(input int cut, output int n, output logic [2:0] f);
        int rem;
        wr_t w;
        rem = m_blk - m_done;
        n = (m_clen < rem) ? m_clen : rem;
        f = 3'b001;
        if (cut > 0 && cut < n) n = cut;
        for (int k = 0; k < n; k++) begin
            w.a = AW'(m_dst + m_doff);
            w.d = pat(m_src + m_soff);
            q.push_back(w);
            m_done++;
            m_soff = (m_soff + 1 == m_slen) ? 0 : m_soff + 1;
            m_doff = (m_doff + 1 == m_dlen) ? 0 : m_doff + 1;
            if (pat_en && w.d == pat_val) begin
                n = k + 1; f = 3'b100; rewind_model(); return;
            end
        end
        if (cut > 0) begin
            f = 3'b100; rewind_model();
        end else if (m_done == m_blk) begin
            f = 3'b011; rewind_model();
        end
    endtask

    task automatic enable();
        @(negedge clk); en_set = 1;
        @(negedge clk); en_set = 0;
    endtask

    task automatic clr(input logic [2:0] m);
        @(negedge clk); flag_clr = m;
        @(negedge clk); flag_clr = '0;
    endtask

    task automatic fire(input bit use_evt, input string req, output logic [2:0] seen);
        int n;
        logic [2:0] f;
        model(0, n, f);
        @(negedge clk);
        if (use_evt) start_evt = 1; else force_go = 1;
        @(negedge clk);
        start_evt = 0; force_go = 0;
        seen = '0;
        repeat (2 * n + 4) begin
            @(negedge clk);
            seen |= stat_flags;
        end
        chk(q.size() == 0, {req, " bytes written"}, q.size(), 0);
        chk(stat_flags == (f | seen & ~flag_clr & 3'b000) || flag_clr != 0,
            {req, " flags"}, int'(stat_flags), int'(f));
        chk(chan_en == !(f[1] | f[2]), {req, " enable"}, int'(chan_en), int'(!(f[1] | f[2])));
    endtask

    logic [2:0] seen;
    int wr_before;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(stat_flags == 0, "R1 flags", int'(stat_flags), 0);
        chk(!lane_irq, "R1 irq", int'(lane_irq), 0);
        chk(!mem_rd && !mem_wr, "R1 no access", int'({mem_rd, mem_wr}), 0);
        chk(!chan_en, "R1 enable", int'(chan_en), 0);

        // R2 trigger ignored while disabled
        cfg(16, 512, 8, 8, 4);
        wr_before = wr_seen;
        @(negedge clk); force_go = 1; @(negedge clk); force_go = 0;
        repeat (12) @(negedge clk);
        chk(wr_seen == wr_before, "R2 disabled trigger writes", wr_seen - wr_before, 0);
        chk(stat_flags == 0, "R2 disabled trigger flags", int'(stat_flags), 0);

        // R7 / R4 two cells of one block
        enable();
        chk(chan_en, "R2 enable set", int'(chan_en), 1);
        fire(0, "R7 first cell", seen);
        clr(3'b111);
        chk(stat_flags == 0, "R11 clear all", int'(stat_flags), 0);
        fire(1, "R4 block end by event", seen);
        wr_before = wr_seen;
        @(negedge clk); start_evt = 1; @(negedge clk); start_evt = 0;
        repeat (12) @(negedge clk);
        chk(wr_seen == wr_before, "R2 trigger after self-clear", wr_seen - wr_before, 0);
        clr(3'b111);

        // R5 source wraps inside a longer destination
        cfg(40, 600, 3, 8, 8);
        enable();
        fire(0, "R5 source wrap", seen);
        chk(mem[603] == pat(40), "R5 source wrap content", int'(mem[603]), int'(pat(40)));
        clr(3'b111);

        // R5 destination wraps under a longer source
        cfg(60, 700, 6, 2, 6);
        enable();
        fire(0, "R5 destination wrap", seen);
        chk(mem[700] == pat(64), "R5 dest wrap last even", int'(mem[700]), int'(pat(64)));
        chk(mem[701] == pat(65), "R5 dest wrap last odd", int'(mem[701]), int'(pat(65)));
        clr(3'b111);

        // R6 cell code 0 (256) larger than block
        cfg(80, 750, 5, 5, 256);
        enable();
        fire(0, "R6 oversize cell", seen);
        clr(3'b111);

        // R6 final cell shortened: 4,4,2
        cfg(100, 800, 10, 10, 4);
        enable();
        fire(0, "R6 cell one", seen); clr(3'b111);
        fire(1, "R6 cell two", seen); clr(3'b111);
        fire(0, "R6 short tail cell", seen); clr(3'b111);

        // R8 pattern match abort
        cfg(120, 820, 8, 8, 8);
        @(negedge clk); pat_en = 1; pat_val = pat(122);
        enable();
        fire(0, "R8 pattern abort", seen);
        chk(!stat_flags[1], "R8 no block flag", int'(stat_flags[1]), 0);
        @(negedge clk); pat_en = 0;
        clr(3'b111);

        // R9 abort while idle, R10 restart at base
        cfg(130, 840, 8, 8, 4);
        enable();
        fire(0, "R9 cell before idle abort", seen);
        clr(3'b111);
        @(negedge clk); abort_evt = 1; @(negedge clk); abort_evt = 0;
        @(negedge clk);
        chk(stat_flags == 3'b100, "R9 idle abort flags", int'(stat_flags), 4);
        chk(!chan_en, "R9 idle abort enable", int'(chan_en), 0);
        rewind_model();
        clr(3'b111);
        enable();
        fire(0, "R10 restart from base", seen);
        fire(0, "R10 finish block", seen);
        clr(3'b111);

        // R9 abort during a transfer: exactly one byte moves
        begin
            int n;
            logic [2:0] f;
            cfg(150, 860, 8, 8, 8);
            enable();
            model(1, n, f);
            @(negedge clk); force_go = 1;
            @(negedge clk); force_go = 0; abort_evt = 1;
            @(negedge clk); abort_evt = 0;
            repeat (6) @(negedge clk);
            chk(q.size() == 0, "R9 in-flight abort bytes", q.size(), 0);
            chk(stat_flags == 3'b100, "R9 in-flight abort flags", int'(stat_flags), 4);
            chk(!chan_en, "R9 in-flight abort enable", int'(chan_en), 0);
        end
        clr(3'b111);
        enable();
        fire(0, "R10 block after abort", seen);
        clr(3'b111);

        // R12 interrupt gating
        cfg(170, 880, 4, 4, 2);
        @(negedge clk); irq_en = 3'b010;
        enable();
        fire(0, "R12 cell with masked irq", seen);
        chk(!lane_irq, "R12 cell flag masked", int'(lane_irq), 0);
        fire(0, "R12 block", seen);
        chk(lane_irq, "R12 block raises irq", int'(lane_irq), 1);
        clr(3'b010);
        chk(!lane_irq, "R12 irq drops after clear", int'(lane_irq), 0);
        chk(stat_flags == 3'b001, "R11 selective clear", int'(stat_flags), 1);
        @(negedge clk); irq_en = '0;
        clr(3'b111);

        // R11 set and clear in the same cycle: set wins for that cycle
        cfg(180, 900, 2, 2, 2);
        enable();
        @(negedge clk); flag_clr = 3'b001;
        fire(0, "R11 race transfer", seen);
        chk(seen[0], "R11 set wins over clear", int'(seen[0]), 1);
        @(negedge clk);
        chk(!stat_flags[0], "R11 cleared afterwards", int'(stat_flags[0]), 0);
        chk(stat_flags[1], "R11 other flag kept", int'(stat_flags[1]), 1);
        flag_clr = '0;

        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule